// File: doc/BRIEF.md
# 12-bit Reload Timer with Input Capture

This block is a free-running 12-bit up-counter behind an 8-bit register port. When the counter passes its all-ones value it restarts from a software-programmed reload value instead of from zero. Each wrap sets an overflow flag. The counter runs from one of two sources chosen by a two-bit field in the control/status byte: every clock cycle, or only on cycles when an external slow-timebase tick is high. The other two codes of the field hold the counter still.

An asynchronous capture input is brought into the clock domain through a flip-flop synchronizer. Each rising edge on it copies the counter into a 12-bit capture register and sets a capture flag. Both flags are cleared by the software read that consumes them: a read of the control/status byte clears the overflow flag, and a read of either capture byte clears the capture flag. Writes to the flags have no effect. A single interrupt line reports each flag gated by its own enable bit.

Software reads the counter as two bytes with no holding latch, so the upper byte can advance between the two reads. The reload value is written as two bytes. A new reload value is used from the next wrap onward.

Top module: `reload_timer12`

## Requirements
- R1: The counter is read at address 1 (bits 3:0 = count[11:8]) and address 2 (count[7:0]). The capture register is read at address 3 (bits 3:0 = capture[11:8]) and address 4 (capture[7:0]). Bits 7:4 of addresses 1 and 3 always read 0. Counter bytes are not latched; each read returns the present value.
- R2: The clock-select field sits in bits 6:5 of the control/status byte at address 0. Codes 00 and 01 hold the counter. Code 10 adds one every clock. Code 11 adds one on each clock where tick_i is high.
- R3: When the counter is at 0xFFF and a count step occurs, its next value is the reload register. The reload register is written and read at address 5 (bits 3:0 = reload[11:8]) and address 6 (reload[7:0]). A newly written reload value is used at the next wrap.
- R4: The overflow flag (control/status bit 0) is set by every wrap. A read strobe (rd_en_i) at address 0 clears it. When a wrap and that read fall in the same cycle, the flag ends up set.
- R5: cap_i passes through two synchronizing flip-flops. Its rising edge loads the counter value into the capture register on the third rising clock edge after cap_i rises, so the flag is not yet set after two edges.
- R6: The capture flag (control/status bit 2) is set by each capture. A read strobe at address 3 or address 4 clears it. When a capture and that read fall in the same cycle, the flag ends up set.
- R7: A write to address 0 stores the overflow enable (bit 1), capture enable (bit 3), compare enable (bit 4) and the clock select (bits 6:5). It leaves both flags unchanged whatever values are written to bits 0 and 2. Bit 7 always reads 0.
- R8: irq_o equals (overflow flag AND overflow enable) OR (capture flag AND capture enable). The compare enable bit has no effect on irq_o.
- R9: After reset the control/status byte, the counter, the reload register and the capture register are all zero, and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Slow-timebase count enable, used with select code 11 |
| cap_i | input | 1 | Asynchronous capture strobe |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; triggers read-to-clear |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two pairs of events can land on the same clock edge: a counter wrap and the control/status read that clears the overflow flag, and a synchronized capture edge and a capture-byte read. The bench runs with a short reload window. It polls the low counter byte and raises the status read in the very cycle the counter shows 0xFFF, then requires the flag to read back as set and the counter to show the newly written reload value. For capture, it counts the synchronizer edges so that the capture-byte read sits on the capture cycle, then requires the capture flag to survive. It also checks that a later read of the capture bytes clears the flag.

// File: rtl/timer12_pkg.sv
package timer12_pkg;

    localparam int ADDR_W = 3;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SEL_HALT_A = 2'b00,
        SEL_HALT_B = 2'b01,
        SEL_FAST   = 2'b10,
        SEL_SLOW   = 2'b11
    } clk_sel_e;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_CAP_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_CAP_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd5;
    localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd6;

    localparam int B_OVF_FLAG = 0;
    localparam int B_OVF_EN   = 1;
    localparam int B_CAP_FLAG = 2;
    localparam int B_CAP_EN   = 3;
    localparam int B_CMP_EN   = 4;
    localparam int B_SEL_LO   = 5;
    localparam int B_SEL_HI   = 6;

endpackage

// File: rtl/tmr_sync_edge.sv
// Multi-stage synchronizer followed by a rising-edge detector.
// STAGES must be 2 or more.
module tmr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], async_i};
        s_d.last  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rise_o = s_q.chain[STAGES-1] & ~s_q.last;

endmodule

// File: rtl/tmr_count_core.sv
// Up-counter that restarts from a reload value after its all-ones state.
module tmr_count_core #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] TOP_VAL = '1;
    localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] value;
    } cnt_t;

    cnt_t c_d, c_q;
    logic at_top;

    always_comb begin
        c_d    = c_q;
        at_top = (c_q.value == TOP_VAL);
        if (run_i) begin
            if (at_top) begin
                c_d.value = reload_i;
            end else begin
                c_d.value = c_q.value + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign count_o = c_q.value;
    assign wrap_o  = run_i & at_top;

endmodule

// File: rtl/tmr_regs.sv
// Byte register file: control/status, reload, capture and read mux.
module tmr_regs
    import timer12_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              tick_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              wrap_i,
    input  logic              cap_evt_i,
    output logic              run_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic [BYTE_W-1:0] rdata_o,
    output logic              ovf_flag_o,
    output logic              ovf_en_o,
    output logic              cap_flag_o,
    output logic              cap_en_o
);

    localparam int HI_W = CNT_W - BYTE_W;

    typedef struct packed {
        logic             ovf_flag;
        logic             ovf_en;
        logic             cap_flag;
        logic             cap_en;
        logic             cmp_en;
        clk_sel_e         sel;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] cap_val;
    } regs_t;

    regs_t r_d, r_q;

    logic wr_ctrl, wr_rld_hi, wr_rld_lo;
    logic rd_ctrl, rd_cap;

    function automatic logic [BYTE_W-1:0] hi_byte(input logic [CNT_W-1:0] v);
        return {{(BYTE_W-HI_W){1'b0}}, v[CNT_W-1:BYTE_W]};
    endfunction

    always_comb begin
        wr_ctrl   = wr_en_i && (addr_i == A_CTRL);
        wr_rld_hi = wr_en_i && (addr_i == A_RLD_HI);
        wr_rld_lo = wr_en_i && (addr_i == A_RLD_LO);
        rd_ctrl   = rd_en_i && (addr_i == A_CTRL);
        rd_cap    = rd_en_i && ((addr_i == A_CAP_HI) || (addr_i == A_CAP_LO));
    end

    always_comb begin
        r_d = r_q;

        // writable control fields; flag bits of the write data are dropped
        if (wr_ctrl) begin
            r_d.ovf_en = wdata_i[B_OVF_EN];
            r_d.cap_en = wdata_i[B_CAP_EN];
            r_d.cmp_en = wdata_i[B_CMP_EN];
            r_d.sel    = clk_sel_e'(wdata_i[B_SEL_HI:B_SEL_LO]);
        end

        if (wr_rld_hi) begin
            r_d.reload[CNT_W-1:BYTE_W] = wdata_i[HI_W-1:0];
        end
        if (wr_rld_lo) begin
            r_d.reload[BYTE_W-1:0] = wdata_i;
        end

        // read-to-clear first, hardware set afterwards so the set wins
        if (rd_ctrl) begin
            r_d.ovf_flag = 1'b0;
        end
        if (wrap_i) begin
            r_d.ovf_flag = 1'b1;
        end

        if (rd_cap) begin
            r_d.cap_flag = 1'b0;
        end
        if (cap_evt_i) begin
            r_d.cap_flag = 1'b1;
            r_d.cap_val  = count_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (addr_i)
            A_CTRL:   rdata_o = {1'b0, r_q.sel, r_q.cmp_en, r_q.cap_en,
                                 r_q.cap_flag, r_q.ovf_en, r_q.ovf_flag};
            A_CNT_HI: rdata_o = hi_byte(count_i);
            A_CNT_LO: rdata_o = count_i[BYTE_W-1:0];
            A_CAP_HI: rdata_o = hi_byte(r_q.cap_val);
            A_CAP_LO: rdata_o = r_q.cap_val[BYTE_W-1:0];
            A_RLD_HI: rdata_o = hi_byte(r_q.reload);
            A_RLD_LO: rdata_o = r_q.reload[BYTE_W-1:0];
            default:  rdata_o = '0;
        endcase
    end

    always_comb begin
        case (r_q.sel)
            SEL_FAST: run_o = 1'b1;
            SEL_SLOW: run_o = tick_i;
            default:  run_o = 1'b0;
        endcase
    end

    assign reload_o   = r_q.reload;
    assign ovf_flag_o = r_q.ovf_flag;
    assign ovf_en_o   = r_q.ovf_en;
    assign cap_flag_o = r_q.cap_flag;
    assign cap_en_o   = r_q.cap_en;

endmodule

// File: rtl/reload_timer12.sv
// 12-bit reload timer with input capture and byte register port.
module reload_timer12
    import timer12_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              cap_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic              irq_o
);

    logic             run_w;
    logic             wrap_w;
    logic             cap_evt_w;
    logic [CNT_W-1:0] count_w;
    logic [CNT_W-1:0] reload_w;
    logic             ovf_flag_w, ovf_en_w, cap_flag_w, cap_en_w;

    tmr_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cap_i),
        .rise_o  (cap_evt_w)
    );

    tmr_count_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_w),
        .reload_i (reload_w),
        .count_o  (count_w),
        .wrap_o   (wrap_w)
    );

    tmr_regs #(
        .CNT_W (CNT_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .rd_en_i    (rd_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .tick_i     (tick_i),
        .count_i    (count_w),
        .wrap_i     (wrap_w),
        .cap_evt_i  (cap_evt_w),
        .run_o      (run_w),
        .reload_o   (reload_w),
        .rdata_o    (rdata_o),
        .ovf_flag_o (ovf_flag_w),
        .ovf_en_o   (ovf_en_w),
        .cap_flag_o (cap_flag_w),
        .cap_en_o   (cap_en_w)
    );

    assign irq_o = (ovf_flag_w & ovf_en_w) | (cap_flag_w & cap_en_w);

endmodule

// File: rtl/timer12_checks.sv
module timer12_checks
    import timer12_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              wrap,
    input logic              cap_evt,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  reload,
    input logic              ovf_flag,
    input logic              cap_flag,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [BYTE_W-1:0] rdata,
    input logic              irq
);

    localparam logic [CNT_W-1:0] TOP_VAL = '1;
    localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt)); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt != TOP_VAL) |=> cnt == $past(cnt) + ONE); // R2

    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> cnt == $past(reload)); // R3

    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf_flag); // R4

    AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_CTRL && !wrap) |=> !ovf_flag); // R4

    AST_CAP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> cap_flag); // R6

    AST_CAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == A_CAP_HI || addr == A_CAP_LO) && !cap_evt) |=> !cap_flag); // R6

    AST_HI_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_CNT_HI || addr == A_CAP_HI) |-> rdata[7:4] == 4'h0); // R1

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_flag && !cap_flag) |-> !irq); // R8

endmodule

bind reload_timer12 timer12_checks #(
    .CNT_W (CNT_W)
) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_w),
    .wrap     (wrap_w),
    .cap_evt  (cap_evt_w),
    .cnt      (count_w),
    .reload   (reload_w),
    .ovf_flag (ovf_flag_w),
    .cap_flag (cap_flag_w),
    .rd_en    (rd_en_i),
    .addr     (addr_i),
    .rdata    (rdata_o),
    .irq      (irq_o)
);

// File: tb/sim_reload_timer12.sv
`timescale 1ns/1ps
module sim_reload_timer12;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick_i, cap_i, wr_en_i, rd_en_i;
    logic [2:0] addr_i;
    logic [7:0] wdata_i;
    logic [7:0] rdata_o;
    logic       irq_o;

    int n_checks = 0;
    int n_fail   = 0;

    logic [11:0] v1, v2;

    always #2.5 clk = ~clk;

    reload_timer12 u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .cap_i   (cap_i),
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .irq_o   (irq_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // look at a register without a read strobe (no side effect)
    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        addr_i = a;
        #1;
        v = rdata_o;
    endtask

    // strobed read: sampled before the edge, side effect at the edge
    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        addr_i  = a;
        rd_en_i = 1'b1;
        #1;
        v = rdata_o;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr_i  = a;
        wdata_i = d;
        wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        @(negedge clk);
        peek(3'd0, v);
        check("R9 ctrl after reset", v, 8'h00);
        check("R9 irq after reset", irq_o, 0);
        @(negedge clk);
        peek(3'd2, v);
        check("R9 count low after reset", v, 8'h00);
        peek(3'd1, v);
        check("R9 count high after reset", v, 8'h00);
        @(negedge clk);
        peek(3'd4, v);
        check("R9 capture low after reset", v, 8'h00);
        peek(3'd6, v);
        check("R9 reload low after reset", v, 8'h00);
        @(negedge clk);
    endtask

    task automatic t_halt();
        logic [7:0] v;
        wr(3'd0, 8'h20);
        tick_i = 1'b1;
        repeat (5) @(negedge clk);
        peek(3'd2, v);
        check("R2 code 01 holds counter", v, 8'h00);
        @(negedge clk);
        wr(3'd0, 8'h00);
        repeat (5) @(negedge clk);
        tick_i = 1'b0;
        peek(3'd2, v);
        check("R2 code 00 holds counter", v, 8'h00);
        @(negedge clk);
    endtask

    task automatic t_fast();
        logic [7:0] v;
        wr(3'd0, 8'h40);
        peek(3'd2, v);
        check("R2 fast start value", v, 8'h00);
        repeat (10) @(negedge clk);
        peek(3'd2, v);
        check("R2 fast counts each clock", v, 8'h0A);
        @(negedge clk);
        wr(3'd0, 8'h00);
        peek(3'd2, v);
        check("R1 count low after stop", v, 8'h0C);
        peek(3'd1, v);
        check("R1 count high after stop", v, 8'h00);
        @(negedge clk);
    endtask

    task automatic t_slow();
        logic [7:0] v;
        wr(3'd0, 8'h60);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
            repeat (2) @(negedge clk);
        end
        wr(3'd0, 8'h00);
        peek(3'd2, v);
        check("R2 slow counts ticks only", v, 8'h0F);
        @(negedge clk);
    endtask

    task automatic t_wrap();
        logic [7:0] v;
        logic       found;
        wr(3'd5, 8'h0F);
        wr(3'd6, 8'hFD);
        peek(3'd5, v);
        check("R3 reload high readback", v, 8'h0F);
        peek(3'd6, v);
        check("R3 reload low readback", v, 8'hFD);
        @(negedge clk);
        wr(3'd0, 8'h40);
        found = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            peek(3'd0, v);
            if (v[0]) begin
                found = 1'b1;
                break;
            end
        end
        check("R4 overflow flag set by wrap", found, 1);
        peek(3'd2, v);
        check("R3 counter restarts at reload", v, 8'hFD);
        check("R8 irq masked by overflow enable", irq_o, 0);
        @(negedge clk);
        peek(3'd1, v);
        check("R1 high byte upper nibble zero", v, 8'h0F);
        @(negedge clk);
        wr(3'd0, 8'h00);
        wr(3'd0, 8'h02);
        peek(3'd0, v);
        check("R7 zero written to flag keeps it", v, 8'h03);
        check("R8 irq on overflow with enable", irq_o, 1);
        @(negedge clk);
        wr(3'd0, 8'h12);
        check("R8 compare enable leaves irq", irq_o, 1);
        wr(3'd0, 8'h10);
        check("R8 compare enable alone no irq", irq_o, 0);
        rd(3'd0, v);
        check("R4 read returns flag before clear", v, 8'h11);
        peek(3'd0, v);
        check("R4 flag cleared by status read", v, 8'h10);
        @(negedge clk);
        wr(3'd0, 8'h95);
        peek(3'd0, v);
        check("R7 ones written to flags and bit7 ignored", v, 8'h10);
        @(negedge clk);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_wrap_vs_read();
        logic [7:0] v;
        logic       hit;
        wr(3'd6, 8'hFB);
        rd(3'd0, v);
        wr(3'd0, 8'h40);
        hit = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            peek(3'd2, v);
            if (v == 8'hFF) begin
                addr_i  = 3'd0;
                rd_en_i = 1'b1;
                @(negedge clk);
                rd_en_i = 1'b0;
                peek(3'd0, v);
                check("R4 wrap beats status read clear", v[0], 1);
                peek(3'd2, v);
                check("R3 new reload used at next wrap", v, 8'hFB);
                hit = 1'b1;
                break;
            end
        end
        check("R3 counter reached top", hit, 1);
        @(negedge clk);
        wr(3'd0, 8'h00);
        rd(3'd0, v);
    endtask

    task automatic t_capture();
        logic [7:0] lo, hi, v;
        @(negedge clk);
        peek(3'd2, lo);
        peek(3'd1, hi);
        v1 = {hi[3:0], lo};
        @(negedge clk);
        wr(3'd0, 8'h08);
        cap_i = 1'b1;
        repeat (2) @(negedge clk);
        peek(3'd0, v);
        check("R5 no capture after two edges", v[2], 0);
        @(negedge clk);
        peek(3'd0, v);
        check("R6 capture flag set", v[2], 1);
        check("R8 irq on capture with enable", irq_o, 1);
        @(negedge clk);
        peek(3'd4, v);
        check("R5 capture low byte", v, int'(v1[7:0]));
        peek(3'd3, v);
        check("R1 capture high byte", v, int'({4'h0, v1[11:8]}));
        @(negedge clk);
        cap_i = 1'b0;
        rd(3'd3, v);
        peek(3'd0, v);
        check("R6 high capture read clears flag", v[2], 0);
        check("R8 irq drops after capture clear", irq_o, 0);
        @(negedge clk);
        // step the counter once by a slow tick, then capture again
        wr(3'd0, 8'h68);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        wr(3'd0, 8'h08);
        v2 = (v1 == 12'hFFF) ? 12'hFFB : v1 + 12'd1;
        cap_i = 1'b1;
        repeat (4) @(negedge clk);
        rd(3'd4, v);
        check("R5 second capture low byte", v, int'(v2[7:0]));
        peek(3'd0, v);
        check("R6 low capture read clears flag", v[2], 0);
        peek(3'd3, v);
        check("R5 second capture high byte", v, int'({4'h0, v2[11:8]}));
        @(negedge clk);
        cap_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_capture_vs_read();
        logic [7:0] v;
        cap_i = 1'b1;
        repeat (2) @(negedge clk);
        addr_i  = 3'd4;
        rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
        peek(3'd0, v);
        check("R6 capture beats capture read clear", v[2], 1);
        @(negedge clk);
        rd(3'd4, v);
        peek(3'd0, v);
        check("R6 later capture read clears", v[2], 0);
        @(negedge clk);
        cap_i = 1'b0;
    endtask

    initial begin
        rst_n   = 1'b0;
        tick_i  = 1'b0;
        cap_i   = 1'b0;
        wr_en_i = 1'b0;
        rd_en_i = 1'b0;
        addr_i  = 3'd0;
        wdata_i = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_halt();
        t_fast();
        t_slow();
        t_wrap();
        t_wrap_vs_read();
        t_capture();
        t_capture_vs_read();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule